// File: doc/BRIEF.md
# Gearbox Width-Conversion FIFO

This block is an elastic buffer that changes bus width by a whole-number factor `N` on a single clock. Words of `W` bits arrive on a valid/ready write port. They leave on a valid/ready read port, either as `W*N`-bit words (pack mode) or as `W/N`-bit words (unpack mode). The mode is fixed by a parameter. A small queue of `W`-bit entries sits in front of a shaping stage. In pack mode the shaping stage is an accumulator; in unpack mode it is a slice selector. Word order is preserved end to end.

Back-pressure rules:
- A transfer takes place on a rising clock edge where both valid and ready are high.
- `in_ready` depends only on the block's own state, never on `in_valid`. Likewise `out_valid` and `out_data` never depend on `out_ready`.
- Once `out_valid` is raised, it stays high with `out_data` unchanged until the word is taken.
- The write side stalls when the queue is full and the shaping stage cannot take another word.
- Full throughput needs the read and write transfer rates to stand in the ratio of the width change: one wide word per `N` input words, or `N` narrow words per input word.

Top module: `gearbox_buf`

## Requirements
- R1: A synchronous active-high `rst` empties the block. On the cycle after reset, `out_valid` is 0 and `in_ready` is 1.
- R2: In pack mode, the first word accepted of a group of `N` occupies bits `[W-1:0]` of the output word. Word k of the group occupies bits `[k*W +: W]`.
- R3: In pack mode, `out_valid` rises only once `N` input words have been collected. A group with fewer than `N` words is never emitted.
- R4: In unpack mode, each input word yields `N` output words in order. Output word k is bits `[k*(W/N) +: W/N]` of the input, so the least significant slice comes first.
- R5: While `out_valid` is high and `out_ready` is low, the next cycle still has `out_valid` high and `out_data` unchanged.
- R6: With `out_ready` held low, the block accepts exactly `DEPTH+N` words in pack mode and `DEPTH+1` words in unpack mode. After that, `in_ready` stays low.
- R7: Under arbitrary valid/ready patterns on both sides, the output stream is exactly the input stream reshaped per R2/R4, with nothing lost, duplicated or reordered.
- R8: Reset discards a partly assembled pack group and a partly drained unpack word. After reset, the next output is built only from words written after it.
- R9: When the ports run at the matching rate ratio with the read side always ready, `in_ready` never drops. In unpack mode, `out_valid` stays high continuously once the stream is running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Write word present |
| in_ready | output | 1 | Block can take a write word |
| in_data | input | W | Write word |
| out_valid | output | 1 | Read word present |
| out_ready | input | 1 | Consumer takes the read word |
| out_data | output | W*N (pack) or W/N (unpack) | Read word |

## Verification
Each mode has its own set of corner cases.
- **Pack mode.** The bench holds a group one word short to catch a design that emits partial groups. A design that fills the accumulator from the top would show reversed word placement.
- **Unpack mode.** The bench checks that slice order starts at the low end. A design that reloads its holding register one cycle late would lose back-to-back throughput at the matched rate.
- **Reset mid-group.** A reset in the middle of a group exposes stale words leaking into the next output.
- **Capacity fill.** The fill test with the read side stalled counts the words accepted. This catches an off-by-one in the full flag, or a shaping stage that takes words it cannot hold.

// File: rtl/gbx_pkg.sv
package gbx_pkg;
  typedef enum logic {
    GBX_PACK   = 1'b0,
    GBX_UNPACK = 1'b1
  } gbx_mode_e;
endpackage

// File: rtl/gbx_queue.sv
module gbx_queue #(
  parameter int W     = 16,
  parameter int DEPTH = 4,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  pop_data,
  output logic          full,
  output logic          empty,
  output logic [LW-1:0] level
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [LW-1:0] lvl_q;
  logic          do_push, do_pop;

  assign full     = (lvl_q == LW'(DEPTH));
  assign empty    = (lvl_q == '0);
  assign do_push  = push && !full;
  assign do_pop   = pop && !empty;
  assign pop_data = mem[rd_q];
  assign level    = lvl_q;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q  <= '0;
      rd_q  <= '0;
      lvl_q <= '0;
    end else begin
      if (do_push) wr_q <= bump(wr_q);
      if (do_pop)  rd_q <= bump(rd_q);
      lvl_q <= lvl_q + LW'(do_push) - LW'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= push_data;
  end
endmodule

// File: rtl/gbx_pack.sv
module gbx_pack #(
  parameter int W  = 16,
  parameter int N  = 4,
  localparam int CW = $clog2(N + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           src_valid,
  input  logic [W-1:0]   src_data,
  output logic           src_take,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [W*N-1:0] out_data
);
  logic [CW-1:0]  cnt_q;
  logic [CW-1:0]  slot;
  logic [W*N-1:0] acc_q;
  logic           group_done, drain;

  assign group_done = (cnt_q == CW'(N));
  assign drain      = group_done && out_ready;
  assign src_take   = src_valid && (!group_done || out_ready);
  assign slot       = drain ? '0 : cnt_q;
  assign out_valid  = group_done;
  assign out_data   = acc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (drain && src_take) begin
      cnt_q <= CW'(1);
    end else if (drain) begin
      cnt_q <= '0;
    end else if (src_take) begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < N; i++) begin
      if (src_take && slot == CW'(i)) acc_q[i*W +: W] <= src_data;
    end
  end
endmodule

// File: rtl/gbx_unpack.sv
module gbx_unpack #(
  parameter int W  = 16,
  parameter int N  = 4,
  localparam int SW = W / N,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          src_valid,
  input  logic [W-1:0]  src_data,
  output logic          src_take,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [SW-1:0] out_data
);
  logic          have_q;
  logic [IW-1:0] idx_q;
  logic [W-1:0]  hold_q;
  logic          fire, last;

  assign fire      = have_q && out_ready;
  assign last      = (idx_q == IW'(N - 1));
  assign src_take  = src_valid && (!have_q || (fire && last));
  assign out_valid = have_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      have_q <= 1'b0;
      idx_q  <= '0;
    end else if (src_take) begin
      have_q <= 1'b1;
      idx_q  <= '0;
    end else if (fire) begin
      if (last) begin
        have_q <= 1'b0;
        idx_q  <= '0;
      end else begin
        idx_q  <= idx_q + IW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (src_take) hold_q <= src_data;
  end

  always_comb begin
    out_data = '0;
    for (int i = 0; i < N; i++) begin
      if (idx_q == IW'(i)) out_data = hold_q[i*SW +: SW];
    end
  end
endmodule

// File: rtl/gearbox_buf.sv
module gearbox_buf #(
  parameter int W     = 16,
  parameter int N     = 4,
  parameter int DEPTH = 4,
  parameter gbx_pkg::gbx_mode_e MODE = gbx_pkg::GBX_PACK
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  output logic in_ready,
  input  logic [W-1:0] in_data,
  output logic out_valid,
  input  logic out_ready,
  output logic [((MODE == gbx_pkg::GBX_PACK) ? W*N : W/N)-1:0] out_data
);
  localparam int OUT_W = (MODE == gbx_pkg::GBX_PACK) ? W*N : W/N;
  localparam int LVL_W = $clog2(DEPTH + 1);

  logic             q_full, q_empty, q_pop;
  logic [W-1:0]     q_data;
  logic [LVL_W-1:0] q_level;

  assign in_ready = !q_full;

  gbx_queue #(.W(W), .DEPTH(DEPTH)) u_queue (
    .clk       (clk),
    .rst       (rst),
    .push      (in_valid),
    .push_data (in_data),
    .pop       (q_pop),
    .pop_data  (q_data),
    .full      (q_full),
    .empty     (q_empty),
    .level     (q_level)
  );

  generate
    if (MODE == gbx_pkg::GBX_PACK) begin : g_pack
      gbx_pack #(.W(W), .N(N)) u_shape (
        .clk       (clk),
        .rst       (rst),
        .src_valid (!q_empty),
        .src_data  (q_data),
        .src_take  (q_pop),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data)
      );
    end else begin : g_unpack
      gbx_unpack #(.W(W), .N(N)) u_shape (
        .clk       (clk),
        .rst       (rst),
        .src_valid (!q_empty),
        .src_data  (q_data),
        .src_take  (q_pop),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data)
      );
    end
  endgenerate
endmodule

// File: rtl/gbx_checker.sv
module gbx_checker #(
  parameter int OW    = 64,
  parameter int DEPTH = 4,
  parameter int LW    = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [OW-1:0] out_data,
  input logic [LW-1:0] level
);
  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> !out_valid); // R1

  AST_HOLD_OUTPUT: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R5

  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    level == LW'(DEPTH) |-> !in_ready); // R6

  AST_EMPTY_ACCEPTS: assert property (@(posedge clk) disable iff (rst)
    level == '0 |-> in_ready); // R6

  AST_WORD_LANDS: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && level == '0 |=> level != '0); // R7
endmodule

bind gearbox_buf gbx_checker #(.OW(OUT_W), .DEPTH(DEPTH), .LW(LVL_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .level     (q_level)
);

// File: tb/test_gearbox_buf.sv
module test_gearbox_buf;
  localparam int W     = 16;
  localparam int N     = 4;
  localparam int DEPTH = 4;
  localparam int PW    = W * N;
  localparam int SW    = W / N;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic          pk_in_valid = 0, pk_in_ready, pk_out_valid, pk_out_ready = 0;
  logic [W-1:0]  pk_in_data = '0;
  logic [PW-1:0] pk_out_data;
  logic          un_in_valid = 0, un_in_ready, un_out_valid, un_out_ready = 0;
  logic [W-1:0]  un_in_data = '0;
  logic [SW-1:0] un_out_data;

  gearbox_buf #(.W(W), .N(N), .DEPTH(DEPTH), .MODE(gbx_pkg::GBX_PACK)) i_gearbox_buf (
    .clk(clk), .rst(rst), .in_valid(pk_in_valid), .in_ready(pk_in_ready), .in_data(pk_in_data),
    .out_valid(pk_out_valid), .out_ready(pk_out_ready), .out_data(pk_out_data));

  gearbox_buf #(.W(W), .N(N), .DEPTH(DEPTH), .MODE(gbx_pkg::GBX_UNPACK)) i_gearbox_buf_un (
    .clk(clk), .rst(rst), .in_valid(un_in_valid), .in_ready(un_in_ready), .in_data(un_in_data),
    .out_valid(un_out_valid), .out_ready(un_out_ready), .out_data(un_out_data));

  int total = 0;
  int bad   = 0;
  logic [W-1:0] pk_q[$];
  logic [W-1:0] un_q[$];
  int un_idx = 0;
  int pk_ins = 0, un_ins = 0, pk_outs = 0, un_outs = 0;
  string pk_tag = "R2";
  string un_tag = "R4";
  logic pk_stall = 0, un_stall = 0;
  logic [PW-1:0] pk_prev = '0;
  logic [SW-1:0] un_prev = '0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [PW-1:0] pack_expect();
    logic [PW-1:0] e = '0;
    for (int k = 0; k < N; k++) e[k*W +: W] = pk_q.pop_front();
    return e;
  endfunction

  function automatic logic [SW-1:0] unpack_expect(input logic [W-1:0] w, input int k);
    return w[k*SW +: SW];
  endfunction

  // Observe one cycle: fires seen here take effect at the coming edge.
  task automatic step();
    #1;
    if (!rst) begin
      if (pk_stall) check(pk_out_valid && pk_out_data == pk_prev, "R5", pk_out_data, pk_prev);
      if (un_stall) check(un_out_valid && un_out_data == un_prev, "R5", 64'(un_out_data), 64'(un_prev));
      if (pk_in_valid && pk_in_ready) begin pk_q.push_back(pk_in_data); pk_ins++; end
      if (un_in_valid && un_in_ready) begin un_q.push_back(un_in_data); un_ins++; end
      if (pk_out_valid && pk_out_ready) begin
        pk_outs++;
        if (pk_q.size() < N) check(1'b0, "R3", 64'(pk_q.size()), 64'(N));
        else begin
          logic [PW-1:0] e = pack_expect();
          check(pk_out_data == e, pk_tag, pk_out_data, e);
        end
      end
      if (un_out_valid && un_out_ready) begin
        un_outs++;
        if (un_q.size() == 0) check(1'b0, un_tag, 64'(un_out_data), 64'hx);
        else begin
          logic [SW-1:0] e = unpack_expect(un_q[0], un_idx);
          check(un_out_data == e, un_tag, 64'(un_out_data), 64'(e));
          un_idx++;
          if (un_idx == N) begin un_idx = 0; void'(un_q.pop_front()); end
        end
      end
      pk_stall = pk_out_valid && !pk_out_ready;
      un_stall = un_out_valid && !un_out_ready;
      pk_prev  = pk_out_data;
      un_prev  = un_out_data;
    end else begin
      pk_stall = 0;
      un_stall = 0;
    end
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    pk_in_valid = 0; un_in_valid = 0; pk_out_ready = 0; un_out_ready = 0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    idle_inputs();
    repeat (3) step();
    rst = 1'b0;
    pk_q.delete(); un_q.delete(); un_idx = 0;
  endtask

  task automatic drive_data();
    pk_in_data = W'($urandom);
    un_in_data = W'($urandom);
  endtask

  initial begin
    int base_pk, base_un;
    void'($urandom(32'd2024));
    @(negedge clk);
    do_reset();

    // R1: idle after reset
    #1;
    check(!pk_out_valid && !un_out_valid, "R1", {pk_out_valid, un_out_valid}, 0);
    check(pk_in_ready && un_in_ready, "R1", {pk_in_ready, un_in_ready}, 2'b11);

    // R3 + R8: partial groups, then reset mid-group
    pk_tag = "R8"; un_tag = "R8";
    pk_out_ready = 1; un_out_ready = 1;
    for (int i = 0; i < 12; i++) begin
      drive_data();
      pk_in_valid = (i < N - 1);
      un_in_valid = (i == 0);
      if (i == 4) un_out_ready = 0;
      step();
      if (i >= N) check(!pk_out_valid, "R3", pk_out_valid, 0);
    end
    do_reset();
    base_pk = pk_outs; base_un = un_outs;
    pk_out_ready = 1; un_out_ready = 1;
    for (int i = 0; i < 14; i++) begin
      drive_data();
      pk_in_valid = (i < N);
      un_in_valid = (i == 0);
      step();
    end
    check(pk_outs - base_pk == 1, "R8", 64'(pk_outs - base_pk), 1);
    check(un_outs - base_un == N, "R8", 64'(un_outs - base_un), 64'(N));
    pk_tag = "R2"; un_tag = "R4";

    // R6: fill with reads stalled
    base_pk = pk_ins; base_un = un_ins;
    idle_inputs();
    for (int i = 0; i < 20; i++) begin
      drive_data();
      pk_in_valid = 1; un_in_valid = 1;
      step();
    end
    check(pk_ins - base_pk == DEPTH + N, "R6", 64'(pk_ins - base_pk), 64'(DEPTH + N));
    check(un_ins - base_un == DEPTH + 1, "R6", 64'(un_ins - base_un), 64'(DEPTH + 1));
    #1;
    check(!pk_in_ready && !un_in_ready, "R6", {pk_in_ready, un_in_ready}, 0);
    idle_inputs();
    pk_out_ready = 1; un_out_ready = 1;
    repeat (30) step();
    check(pk_q.size() == 0 && un_q.size() == 0, "R6", 64'(pk_q.size() + un_q.size()), 0);

    // R9: matched rate ratio, read side always ready
    for (int i = 0; i < 40; i++) begin
      drive_data();
      pk_in_valid = 1;
      un_in_valid = (i % N == 0);
      step();
      check(pk_in_ready, "R9", pk_in_ready, 1);
      check(un_in_ready, "R9", un_in_ready, 1);
      if (i >= 2) check(un_out_valid, "R9", un_out_valid, 1);
    end
    idle_inputs();
    pk_out_ready = 1; un_out_ready = 1;
    repeat (20) step();

    // R7: random traffic on both sides
    pk_tag = "R7"; un_tag = "R7";
    for (int i = 0; i < 3000; i++) begin
      drive_data();
      pk_in_valid  = ($urandom % 4) != 0;
      pk_out_ready = ($urandom % 3) != 0;
      un_in_valid  = ($urandom % 5) == 0;
      un_out_ready = ($urandom % 4) != 0;
      step();
    end
    idle_inputs();
    pk_out_ready = 1; un_out_ready = 1;
    repeat (60) step();
    check(pk_q.size() < N, "R7", 64'(pk_q.size()), 64'(N - 1));
    check(un_q.size() == 0, "R7", 64'(un_q.size()), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule